// File: doc/BRIEF.md
# Handshake timeout fail-safe monitor

This block sits beside a request/acknowledge handshake between a host-side bridge and an internal core. Each time the request (or strobe) line rises, it starts a down-counter loaded from a 16-bit reload value given in clock ticks. If the core's acknowledge has not been seen by the time the counter runs out, a sticky fail-safe error is recorded. What happens next depends on a two-bit mode field. One mode switches monitoring off. One mode only flags the error. The two halt modes also freeze further monitoring and assert a halt output until software clears the error.

Software reaches the monitor through a small synchronous register port. The port has a control register, a status register and a write-only command register. A separate qualifier marks status reads that fetch the upper word. When auto-clear is enabled, such a read clears the error. Otherwise, a command bit clears it.

A single interrupt output merges three sources, each behind its own enable: an interrupt line from the core, the fail-safe error, and a sticky read-discard event. The status register mirrors the state of the interrupt pin.

Top module: `hs_failsafe_mon`

## Requirements
- R1: A rising edge of `core_req`, sampled at clock edge E0, starts a measurement. If `core_ack` is not sampled high on any of the edges E0+1 … E0+TMO+1 (TMO = `tmo_reload`), the fail-safe error is set at edge E0+TMO+1. An acknowledge sampled on any of those edges ends the measurement with no error.
- R2: Mode field control[17:16] encodes 00 = off, 01 = flag only, 10 = halt and 11 = halt. In mode 00 no measurement runs and the error never becomes set.
- R3: After reset: control reads 0x0002_0000 (halt mode), status reads 0, and `halt_o`, `irq_o` and `reg_rdata` are 0.
- R4: The fail-safe error is sticky and reads as status bit 22 (address 0). It stays set until one of the clear actions in R6 or R7 occurs.
- R5: In a halt mode, `halt_o` rises on the same edge as the error. It stays high until the error is cleared, and no new measurement starts while it is high.
- R6: Writing address 2 with bit 1 set clears the error and `halt_o` on that write edge. With auto-clear off, status reads never clear the error.
- R7: With auto-clear (control bit 18) set, a status read with `reg_rd_upper` high clears the error and `halt_o`. The data that read returns still shows the error.
- R8: In flag-only mode `halt_o` stays low, and a later request rising edge starts a new measurement whether or not the error is set.
- R9: `irq_o` is registered one cycle after its inputs. It is the OR of `core_irq` gated by control bit 21, the error gated by control bit 19 and a mode other than off, and the discard flag gated by control bit 20. Status bit 31 shows `irq_o`.
- R10: A `discard_evt` pulse sets a sticky discard flag, read as status bit 21. Writing address 2 with bit 2 set clears it.
- R11: `reg_rdata` is loaded on the edge that samples `reg_rd` and holds otherwise. Only control bits 21:16 are writable. All other control bits, the command register and address 3 read 0. Writes to status are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_reload | input | 16 | Timeout reload value in clock ticks |
| core_req | input | 1 | Request/strobe toward the core |
| core_ack | input | 1 | Handshake answer from the core |
| core_irq | input | 1 | Interrupt line from the core |
| discard_evt | input | 1 | Single-cycle read-discard event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rd_upper | input | 1 | Read includes the status upper word |
| reg_addr | input | 2 | Register address (0 status, 1 control, 2 command) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| halt_o | output | 1 | Halt request after a timeout in halt mode |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle. The error never appears while the mode is off and the error is clear. The error is sticky unless a clear action occurs. `halt_o` never stands without the error. An auto-clearing upper-word read always empties the error. A running count steps down by one each idle cycle, and the interrupt follows an enabled error. Only the bench scenarios can show the exact timeout edge and the ack-in-time case. The same applies to the returned data of a clearing read, the restart in flag-only mode, the reserved-bit masking and the per-source interrupt gating.

// File: rtl/hsfs_pkg.sv
package hsfs_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_FLAG  = 2'b01,
    MODE_HALT  = 2'b10,
    MODE_HALT2 = 2'b11
  } fs_mode_e;

  localparam addr_t A_STAT = 2'd0;
  localparam addr_t A_CTRL = 2'd1;
  localparam addr_t A_CMD  = 2'd2;

  localparam int B_IRQ      = 31;
  localparam int B_FSERR    = 22;
  localparam int B_DISC     = 21;
  localparam int B_EN_CORE  = 21;
  localparam int B_EN_DISC  = 20;
  localparam int B_EN_FS    = 19;
  localparam int B_AUTOCLR  = 18;
  localparam int B_MODE_LO  = 16;
  localparam int B_CLR_FS   = 1;
  localparam int B_CLR_DISC = 2;

  function automatic logic mode_halts(fs_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/hsfs_timer.sv
module hsfs_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             req,
  input  logic             ack,
  input  logic [CNT_W-1:0] reload,
  output logic             timeout
);
  logic             req_q;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic             req_rise;

  assign req_rise = req && !req_q;
  assign timeout  = enable && running && !ack && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      req_q <= req;
      if (!enable) begin
        running <= 1'b0;
      end else if (running) begin
        if (ack || cnt == '0) running <= 1'b0;
        else                  cnt     <= cnt - 1'b1;
      end else if (req_rise) begin
        running <= 1'b1;
        cnt     <= reload;
      end
    end
  end

  // R1: an unanswered running count steps down by one per cycle
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (enable && running && !ack && cnt != '0) |=> (running && cnt == $past(cnt) - 1'b1));

  // R2: a disabled monitor never keeps a measurement running
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !running);
endmodule

// File: rtl/hsfs_regs.sv
module hsfs_regs
  import hsfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             rd_upper,
  input  addr_t            addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             timeout,
  input  logic             disc_evt,
  input  logic             irq_q,
  output fs_mode_e         mode,
  output logic             en_core,
  output logic             en_disc,
  output logic             en_fs,
  output logic             fs_err,
  output logic             disc_flag,
  output logic             halt,
  output logic [REG_W-1:0] rdata
);
  logic autoclr;
  logic cmd_wr, ctrl_wr;
  logic clr_fs, clr_disc;
  logic [REG_W-1:0] rd_mux;
  logic unused_wbits;

  assign cmd_wr   = wr_en && (addr == A_CMD);
  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign clr_fs   = (cmd_wr && wdata[B_CLR_FS]) ||
                    (rd_en && rd_upper && (addr == A_STAT) && autoclr);
  assign clr_disc = cmd_wr && wdata[B_CLR_DISC];
  assign unused_wbits = ^{wdata[31:22], wdata[15:3], wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_HALT;
      en_core <= 1'b0;
      en_disc <= 1'b0;
      en_fs   <= 1'b0;
      autoclr <= 1'b0;
    end else if (ctrl_wr) begin
      mode    <= fs_mode_e'(wdata[B_MODE_LO+1:B_MODE_LO]);
      en_core <= wdata[B_EN_CORE];
      en_disc <= wdata[B_EN_DISC];
      en_fs   <= wdata[B_EN_FS];
      autoclr <= wdata[B_AUTOCLR];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_err    <= 1'b0;
      halt      <= 1'b0;
      disc_flag <= 1'b0;
    end else begin
      if (timeout)     fs_err <= 1'b1;
      else if (clr_fs) fs_err <= 1'b0;

      if (timeout && mode_halts(mode)) halt <= 1'b1;
      else if (clr_fs)                 halt <= 1'b0;

      if (disc_evt)      disc_flag <= 1'b1;
      else if (clr_disc) disc_flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rd_mux = {irq_q, 8'b0, fs_err, disc_flag, 21'b0};
      A_CTRL:  rd_mux = {10'b0, en_core, en_disc, en_fs, autoclr, mode, 16'b0};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R4: the error persists unless a clear action occurs
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (fs_err && !clr_fs) |=> fs_err);

  // R2: with monitoring off a clear error stays clear
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF && !fs_err) |=> !fs_err);

  // R5: halt never stands without the error behind it
  p_halt_has_err_r5: assert property (@(posedge clk) disable iff (rst)
    halt |-> fs_err);

  // R7: an auto-clearing upper-word status read empties the error
  p_autoclr_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_upper && addr == A_STAT && autoclr && !timeout) |=> !fs_err);
endmodule

// File: rtl/hsfs_irq.sv
module hsfs_irq (
  input  logic clk,
  input  logic rst,
  input  logic core_irq,
  input  logic en_core,
  input  logic fs_err,
  input  logic en_fs,
  input  logic mon_on,
  input  logic disc_flag,
  input  logic en_disc,
  output logic irq_q
);
  logic src_core, src_fs, src_disc;

  assign src_core = core_irq && en_core;
  assign src_fs   = fs_err && en_fs && mon_on;
  assign src_disc = disc_flag && en_disc;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= src_core || src_fs || src_disc;
  end

  // R9: an enabled error in an active mode raises the interrupt next cycle
  p_fs_raises_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (fs_err && en_fs && mon_on) |=> irq_q);
endmodule

// File: rtl/hs_failsafe_mon.sv
module hs_failsafe_mon
  import hsfs_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMO_W-1:0] tmo_reload,
  input  logic             core_req,
  input  logic             core_ack,
  input  logic             core_irq,
  input  logic             discard_evt,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_rd_upper,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             halt_o,
  output logic             irq_o
);
  fs_mode_e mode;
  logic en_core, en_disc, en_fs;
  logic fs_err, disc_flag, halt;
  logic timeout, tmr_en, mon_on, irq_q;

  assign mon_on = (mode != MODE_OFF);
  assign tmr_en = mon_on && !halt;

  hsfs_timer #(.CNT_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .enable(tmr_en), .req(core_req), .ack(core_ack),
    .reload(tmo_reload), .timeout(timeout)
  );

  hsfs_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .rd_upper(reg_rd_upper),
    .addr(reg_addr), .wdata(reg_wdata), .timeout(timeout), .disc_evt(discard_evt),
    .irq_q(irq_q), .mode(mode), .en_core(en_core), .en_disc(en_disc), .en_fs(en_fs),
    .fs_err(fs_err), .disc_flag(disc_flag), .halt(halt), .rdata(reg_rdata)
  );

  hsfs_irq u_irq (
    .clk(clk), .rst(rst), .core_irq(core_irq), .en_core(en_core), .fs_err(fs_err),
    .en_fs(en_fs), .mon_on(mon_on), .disc_flag(disc_flag), .en_disc(en_disc),
    .irq_q(irq_q)
  );

  assign halt_o = halt;
  assign irq_o  = irq_q;
endmodule

// File: tb/sim_hs_failsafe_mon.sv
`timescale 1ns/1ps
module sim_hs_failsafe_mon;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] tmo_reload = 16'd5;
  logic core_req = 0, core_ack = 0, core_irq = 0, discard_evt = 0;
  logic reg_wr = 0, reg_rd = 0, reg_rd_upper = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic halt_o, irq_o;
  int n_run = 0, n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  hs_failsafe_mon u0 (
    .clk(clk), .rst(rst), .tmo_reload(tmo_reload), .core_req(core_req),
    .core_ack(core_ack), .core_irq(core_irq), .discard_evt(discard_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rd_upper(reg_rd_upper),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .halt_o(halt_o), .irq_o(irq_o)
  );

  // entry: {op (0 write, 1 read-compare), addr, data}
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {2'd1, 2'd1, 32'h0002_0000},  // R3 control reset value
    {2'd0, 2'd1, 32'hFFFF_FFFF},
    {2'd1, 2'd1, 32'h003F_0000},  // R11 only 21:16 writable
    {2'd1, 2'd0, 32'h0000_0000},
    {2'd0, 2'd0, 32'hFFFF_FFFF},
    {2'd1, 2'd0, 32'h0000_0000},  // R11 status write ignored
    {2'd1, 2'd2, 32'h0000_0000},  // R11 command reads 0
    {2'd0, 2'd1, 32'h0001_0000},
    {2'd1, 2'd1, 32'h0001_0000},
    {2'd0, 2'd1, 32'h0000_0000},
    {2'd1, 2'd1, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic up, output logic [31:0] d);
    reg_rd = 1; reg_addr = a; reg_rd_upper = up;
    @(negedge clk);
    reg_rd = 0; reg_rd_upper = 0;
    d = reg_rdata;
  endtask

  task automatic req_pulse_start();
    core_req = 0;
    @(negedge clk);
    core_req = 1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R3 reset state
    chk("R3 halt", {31'b0, halt_o}, 32'd0);
    chk("R3 irq", {31'b0, irq_o}, 32'd0);
    chk("R3 rdata", reg_rdata, 32'd0);
    rd(2'd0, 1'b0, rv);
    chk("R3 status", rv, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35:34] == 2'd0) wr(VEC[i][33:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][33:32], 1'b0, rv);
        chk($sformatf("R11 table entry %0d", i), rv, VEC[i][31:0]);
      end
    end

    // R1 R5: halt mode, fs irq enabled, timeout with TMO=5
    wr(2'd1, 32'h000A_0000);
    req_pulse_start();
    repeat (6) @(negedge clk);
    chk("R1 no error before window end", {31'b0, halt_o}, 32'd0);
    @(negedge clk);
    chk("R5 halt at timeout edge", {31'b0, halt_o}, 32'd1);
    chk("R9 irq latency", {31'b0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, irq_o}, 32'd1);
    // R5: new request while halted is ignored, halt held
    req_pulse_start();
    repeat (10) @(negedge clk);
    chk("R5 halt held", {31'b0, halt_o}, 32'd1);
    core_req = 0;
    // R6: no autoclear, reads leave error set
    rd(2'd0, 1'b1, rv);
    chk("R4 status error bit", rv, 32'h8040_0000);
    rd(2'd0, 1'b0, rv);
    chk("R6 read does not clear", rv, 32'h8040_0000);
    wr(2'd2, 32'h0000_0002);
    chk("R6 halt cleared by command", {31'b0, halt_o}, 32'd0);
    @(negedge clk);
    chk("R6 irq cleared", {31'b0, irq_o}, 32'd0);

    // R1: ack on the last edge of the window prevents the error
    req_pulse_start();
    repeat (6) @(negedge clk);
    core_ack = 1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1 ack in time no halt", {31'b0, halt_o}, 32'd0);
    chk("R1 ack in time no irq", {31'b0, irq_o}, 32'd0);
    core_req = 0; core_ack = 0;

    // R2: mode off, no error
    wr(2'd1, 32'h0008_0000);
    req_pulse_start();
    repeat (20) @(negedge clk);
    chk("R2 off no irq", {31'b0, irq_o}, 32'd0);
    rd(2'd0, 1'b0, rv);
    chk("R2 off no error", rv, 32'd0);
    core_req = 0;

    // R8 R7: flag-only with autoclear
    wr(2'd1, 32'h000D_0000);
    req_pulse_start();
    repeat (8) @(negedge clk);
    chk("R8 flag mode irq", {31'b0, irq_o}, 32'd1);
    chk("R8 flag mode no halt", {31'b0, halt_o}, 32'd0);
    rd(2'd0, 1'b0, rv);
    chk("R7 lower read keeps error", rv, 32'h8040_0000);
    rd(2'd0, 1'b1, rv);
    chk("R7 clearing read returns error", rv, 32'h8040_0000);
    @(negedge clk);
    chk("R7 irq gone after autoclear", {31'b0, irq_o}, 32'd0);
    rd(2'd0, 1'b0, rv);
    chk("R7 status empty", rv, 32'd0);
    // R8: next request measures again
    req_pulse_start();
    repeat (8) @(negedge clk);
    chk("R8 restart raises error again", {31'b0, irq_o}, 32'd1);
    core_req = 0;
    wr(2'd2, 32'h0000_0002);
    @(negedge clk);
    chk("R6 command clear in flag mode", {31'b0, irq_o}, 32'd0);

    // R9: core interrupt gating
    wr(2'd1, 32'h0020_0000);
    core_irq = 1;
    @(negedge clk);
    chk("R9 core irq enabled", {31'b0, irq_o}, 32'd1);
    rd(2'd0, 1'b0, rv);
    chk("R9 status mirrors pin", rv, 32'h8000_0000);
    wr(2'd1, 32'h0000_0000);
    @(negedge clk);
    chk("R9 core irq masked", {31'b0, irq_o}, 32'd0);
    core_irq = 0;

    // R10: discard event
    wr(2'd1, 32'h0010_0000);
    discard_evt = 1;
    @(negedge clk);
    discard_evt = 0;
    @(negedge clk);
    chk("R10 discard irq", {31'b0, irq_o}, 32'd1);
    rd(2'd0, 1'b0, rv);
    chk("R10 discard status", rv, 32'h8020_0000);
    wr(2'd2, 32'h0000_0004);
    @(negedge clk);
    chk("R10 discard cleared", {31'b0, irq_o}, 32'd0);
    wr(2'd1, 32'h0000_0000);
    discard_evt = 1;
    @(negedge clk);
    discard_evt = 0;
    @(negedge clk);
    rd(2'd0, 1'b0, rv);
    chk("R10 masked discard flag only", rv, 32'h0020_0000);
    chk("R9 masked discard no irq", {31'b0, irq_o}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule